// File: doc/BRIEF.md
# Misaligned Data Alignment Unit

This execution unit supports 64-bit accesses that do not fall on an 8-byte boundary. It accepts one decoded instruction word per cycle and handles three operations. Two address operations add two 64-bit integer operands. They return the sum rounded down to a multiple of eight, and they record a 3-bit byte offset in a register inside the unit. The data operation joins two 64-bit floating operands into a 16-byte window and extracts the eight bytes that begin at the recorded offset. Software issues an address operation, loads the two aligned doublewords that straddle the wanted data, and then issues the data operation to obtain the unaligned value.

The shift amount never travels with the data instruction. It persists from the most recent address operation. The little-endian address variant stores the negated offset (modulo 8), which sets up the opposite byte ordering for a later data operation. All results are registered. Each appears one cycle after the input strobe, together with a one-cycle valid pulse on the output that was written. The unit is always ready: it has no back-pressure, so an instruction offered on any cycle is taken, and a consumer must capture a result in the cycle its valid pulse is high.

Top module: `mda_align_unit`

## Requirements
- R1: An address operation (opf 9'h018 or 9'h01A) returns `int_res` = (int_a + int_b) modulo 2^64 with bits [2:0] cleared, and pulses `int_res_valid` for one cycle, one cycle after the strobe.
- R2: The big-endian address operation (opf 9'h018) stores bits [2:0] of the sum in the offset register.
- R3: The little-endian address operation (opf 9'h01A) stores (8 - sum[2:0]) modulo 8 in the offset register.
- R4: The data operation (opf 9'h048) numbers the bytes of {fp_a, fp_b} 0 to 15, with byte 0 as the most significant byte of fp_a. It returns the eight bytes starting at byte number `offset` in `fp_res`, most significant first, and pulses `fp_res_valid` one cycle after the strobe.
- R5: An instruction is taken only when bits [31:30] = 2'b10 and bits [24:19] = 6'b110110, with opf in bits [13:5]. Any other word produces no valid pulse, no illegal flag and no offset change.
- R6: A matching format with an unrecognised opf pulses `illegal_op` for one cycle, produces no result valid, and leaves the offset unchanged.
- R7: After reset, the offset is 0 and all outputs are 0.
- R8: The offset register changes only on a taken address operation. It holds across data operations, idle cycles and strobe-low cycles.
- R9: A data operation issued in the cycle right after an address operation uses the offset that the address operation wrote.
- R10: With `in_valid` low, no valid pulse and no illegal flag appear in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| int_a | input | 64 | First integer operand |
| int_b | input | 64 | Second integer operand |
| fp_a | input | 64 | Upper half of the byte window |
| fp_b | input | 64 | Lower half of the byte window |
| int_res | output | 64 | Aligned address result |
| int_res_valid | output | 1 | One-cycle pulse for int_res |
| fp_res | output | 64 | Extracted doubleword |
| fp_res_valid | output | 1 | One-cycle pulse for fp_res |
| illegal_op | output | 1 | One-cycle pulse for an unknown opf |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before any strobe. They also assume that input words are fully driven whenever `in_valid` is high, so that decode never sees unknown values. The stimulus drives every input at the falling edge and releases `in_valid` after a single cycle. Operands are always defined, and reset is applied before the first instruction. Because the offset is not visible at the ports, each offset is observed through a subsequent data operation.

// File: rtl/mda_pkg.sv
package mda_pkg;
  localparam int DATA_W = 64;
  localparam int BYTES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(BYTES);

  localparam logic [1:0] FMT_TOP = 2'b10;
  localparam logic [5:0] FMT_MID = 6'b110110;

  localparam logic [8:0] OPF_ADDR    = 9'h018;
  localparam logic [8:0] OPF_ADDR_LE = 9'h01A;
  localparam logic [8:0] OPF_ALIGN   = 9'h048;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_ADDR,
    OP_ADDR_LE,
    OP_ALIGN,
    OP_BAD
  } op_e;
endpackage

// File: rtl/mda_decode.sv
module mda_decode
  import mda_pkg::*;
(
  input  logic        in_valid,
  input  logic [31:0] instr,
  output op_e         op
);
  logic       fmt_ok;
  logic [8:0] opf;
  logic       unused_fields;

  assign fmt_ok        = (instr[31:30] == FMT_TOP) && (instr[24:19] == FMT_MID);
  assign opf           = instr[13:5];
  assign unused_fields = ^{instr[29:25], instr[18:14], instr[4:0]};

  always_comb begin
    op = OP_NONE;
    if (in_valid && fmt_ok) begin
      unique case (opf)
        OPF_ADDR:    op = OP_ADDR;
        OPF_ADDR_LE: op = OP_ADDR_LE;
        OPF_ALIGN:   op = OP_ALIGN;
        default:     op = OP_BAD;
      endcase
    end
  end
endmodule

// File: rtl/mda_addr_gen.sv
module mda_addr_gen #(
  parameter int W     = 64,
  parameter int OFF_W = 3
) (
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic             little,
  output logic [W-1:0]     aligned,
  output logic [OFF_W-1:0] new_off
);
  logic [W-1:0]     sum;
  logic [OFF_W-1:0] low;

  assign sum     = a + b;
  assign low     = sum[OFF_W-1:0];
  assign aligned = {sum[W-1:OFF_W], {OFF_W{1'b0}}};
  assign new_off = little ? (~low + OFF_W'(1)) : low;
endmodule

// File: rtl/mda_byte_align.sv
module mda_byte_align #(
  parameter int BYTES = 8,
  parameter int OFF_W = 3
) (
  input  logic [BYTES*8-1:0] hi,
  input  logic [BYTES*8-1:0] lo,
  input  logic [OFF_W-1:0]   off,
  output logic [BYTES*8-1:0] res
);
  localparam int WIN = 2 * BYTES;

  logic [WIN*8-1:0] window;
  logic [7:0]       win_byte [WIN];

  assign window = {hi, lo};

  always_comb begin
    for (int k = 0; k < WIN; k++) begin
      win_byte[k] = window[(WIN-1-k)*8 +: 8];
    end
  end

  for (genvar j = 0; j < BYTES; j++) begin : g_lane
    logic [OFF_W:0] idx;
    assign idx = {1'b0, off} + (OFF_W+1)'(j);
    assign res[(BYTES-1-j)*8 +: 8] = win_byte[idx];
  end
endmodule

// File: rtl/mda_align_unit.sv
module mda_align_unit
  import mda_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] int_a,
  input  logic [DATA_W-1:0] int_b,
  input  logic [DATA_W-1:0] fp_a,
  input  logic [DATA_W-1:0] fp_b,
  output logic [DATA_W-1:0] int_res,
  output logic              int_res_valid,
  output logic [DATA_W-1:0] fp_res,
  output logic              fp_res_valid,
  output logic              illegal_op
);
  op_e              op;
  logic [OFF_W-1:0] off_q;
  logic [DATA_W-1:0] addr_aligned;
  logic [OFF_W-1:0] addr_off;
  logic [DATA_W-1:0] align_data;
  logic             is_addr;

  mda_decode u_dec (
    .in_valid (in_valid),
    .instr    (instr),
    .op       (op)
  );

  mda_addr_gen #(.W(DATA_W), .OFF_W(OFF_W)) u_addr (
    .a       (int_a),
    .b       (int_b),
    .little  (op == OP_ADDR_LE),
    .aligned (addr_aligned),
    .new_off (addr_off)
  );

  mda_byte_align #(.BYTES(BYTES), .OFF_W(OFF_W)) u_align (
    .hi  (fp_a),
    .lo  (fp_b),
    .off (off_q),
    .res (align_data)
  );

  assign is_addr = (op == OP_ADDR) || (op == OP_ADDR_LE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q         <= '0;
      int_res       <= '0;
      fp_res        <= '0;
      int_res_valid <= 1'b0;
      fp_res_valid  <= 1'b0;
      illegal_op    <= 1'b0;
    end else begin
      int_res_valid <= is_addr;
      fp_res_valid  <= (op == OP_ALIGN);
      illegal_op    <= (op == OP_BAD);
      if (is_addr) begin
        int_res <= addr_aligned;
        off_q   <= addr_off;
      end
      if (op == OP_ALIGN) fp_res <= align_data;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_res_valid, fp_res_valid, illegal_op})); // R5
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    int_res_valid |-> (int_res[OFF_W-1:0] == '0)); // R1
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !is_addr |=> $stable(off_q)); // R8
  AST_BAD_KEEPS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BAD) |=> (illegal_op && $stable(off_q))); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !(int_res_valid || fp_res_valid || illegal_op)); // R10
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (int_res_valid && !is_addr) |=> !int_res_valid); // R1
endmodule

// File: tb/mda_align_unit_test.sv
module mda_align_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] int_a = '0, int_b = '0, fp_a = '0, fp_b = '0;
  logic [63:0] int_res, fp_res;
  logic        int_res_valid, fp_res_valid, illegal_op;
  int checks = 0;
  int errors = 0;
  logic [2:0] model_off = 3'd0;

  always #4 clk = ~clk;

  mda_align_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .int_a(int_a), .int_b(int_b), .fp_a(fp_a), .fp_b(fp_b),
    .int_res(int_res), .int_res_valid(int_res_valid),
    .fp_res(fp_res), .fp_res_valid(fp_res_valid), .illegal_op(illegal_op)
  );

  function automatic logic [31:0] mk(input logic [8:0] opf);
    return {2'b10, 5'd3, 6'b110110, 5'd7, opf, 5'd9};
  endfunction

  function automatic logic [63:0] ref_align(input logic [63:0] hi, input logic [63:0] lo,
                                            input logic [2:0] off);
    logic [7:0] b [16];
    logic [63:0] r;
    for (int i = 0; i < 8; i++) begin
      b[i]   = hi[63-8*i -: 8];
      b[i+8] = lo[63-8*i -: 8];
    end
    r = '0;
    for (int j = 0; j < 8; j++) r[63-8*j -: 8] = b[int'(off) + j];
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic issue(input logic v, input logic [31:0] w, input logic [63:0] a,
                       input logic [63:0] b, input logic [63:0] fa, input logic [63:0] fb);
    @(negedge clk);
    in_valid = v; instr = w; int_a = a; int_b = b; fp_a = fa; fp_b = fb;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic probe_align(input string req, input int k);
    logic [63:0] fa, fb;
    fa = 64'h8091A2B3C4D5E6F7 + 64'(k);
    fb = 64'h08192A3B4C5D6E7F - 64'(k);
    issue(1'b1, mk(9'h048), '0, '0, fa, fb);
    chk(req, {63'd0, fp_res_valid}, 64'd1);
    chk(req, fp_res, ref_align(fa, fb, model_off));
    chk(req, {61'd0, int_res_valid, illegal_op, 1'b0}, 64'd0);
  endtask

  task automatic do_addr(input logic little, input int s, input int k);
    logic [63:0] a, b, sum;
    a = 64'hFEDCBA9876543210 + 64'(k) * 64'h0000_0111_0000_0101;
    b = 64'h13579BDF2468ACE0;
    sum = a + b;
    b = b + 64'((s - int'(sum[2:0])) & 7);
    sum = a + b;
    issue(1'b1, mk(little ? 9'h01A : 9'h018), a, b, '0, '0);
    chk("R1", {63'd0, int_res_valid}, 64'd1);
    chk("R1", int_res, sum & ~64'd7);
    model_off = little ? 3'((8 - s) % 8) : 3'(s);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7", {int_res_valid, fp_res_valid, illegal_op}, 64'd0);
    chk("R7", int_res, 64'd0);
    chk("R7", fp_res, 64'd0);
    rst_n = 1'b1;
    probe_align("R7", 99);

    // R2 / R3 / R4: every offset, both endian variants
    for (int le = 0; le < 2; le++) begin
      for (int s = 0; s < 8; s++) begin
        do_addr(le[0], s, s + 8 * le);
        probe_align(le != 0 ? "R3" : "R2", s * 3 + le);
        probe_align("R4", s + 40);
      end
    end

    // R8: offset set to 5, survives idle cycles and data operations
    do_addr(1'b0, 5, 1);
    repeat (4) @(negedge clk);
    probe_align("R8", 2);
    probe_align("R8", 3);

    // R6: unknown opf
    issue(1'b1, mk(9'h049), 64'h7, 64'h1, '0, '0);
    chk("R6", {61'd0, int_res_valid, fp_res_valid, illegal_op}, 64'd1);
    @(negedge clk);
    chk("R6", {63'd0, illegal_op}, 64'd0);
    probe_align("R6", 4);

    // R5: wrong format bits, otherwise an address op
    issue(1'b1, {2'b11, mk(9'h018)[29:0]}, 64'h3, 64'h0, '0, '0);
    chk("R5", {61'd0, int_res_valid, fp_res_valid, illegal_op}, 64'd0);
    issue(1'b1, {mk(9'h018)[31:25], 6'b110111, mk(9'h018)[18:0]}, 64'h3, 64'h0, '0, '0);
    chk("R5", {61'd0, int_res_valid, fp_res_valid, illegal_op}, 64'd0);
    probe_align("R5", 5);

    // R10: strobe low with a valid-looking address op
    issue(1'b0, mk(9'h01A), 64'h1, 64'h0, '0, '0);
    chk("R10", {61'd0, int_res_valid, fp_res_valid, illegal_op}, 64'd0);
    probe_align("R10", 6);

    // R9: data op directly after address op
    @(negedge clk);
    in_valid = 1'b1; instr = mk(9'h01A);
    int_a = 64'h1000; int_b = 64'h6; fp_a = '0; fp_b = '0;
    @(negedge clk);
    chk("R9", int_res, 64'h1000);
    model_off = 3'd2;
    instr = mk(9'h048); fp_a = 64'h0102030405060708; fp_b = 64'h090A0B0C0D0E0F10;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9", {63'd0, fp_res_valid}, 64'd1);
    chk("R9", fp_res, 64'h030405060708090A);

    // R1: carry wraps through bit 63
    issue(1'b1, mk(9'h018), 64'hFFFFFFFFFFFFFFFF, 64'h000000000000000C, '0, '0);
    chk("R1", int_res, 64'h0000000000000008);
    summary();
  end
endmodule